// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block sits on a two-wire serial bus (I2C) as a target device that behaves like a small byte-addressed non-volatile memory. It watches the clock and data lines, oversamples them with its own system clock, and recognises start, repeated-start and stop conditions. An address byte selects the device when its upper nibble equals a fixed device prefix and its next three bits equal the three strap inputs. Up to eight such devices can therefore share one bus.

A write transaction sets the internal byte pointer from the first byte after the address. Every later byte in the same transaction is stored at the pointer, and the pointer then advances. A read transaction, usually opened by a repeated start after a write that only set the pointer, returns the byte at the pointer, most significant bit first. The read continues byte by byte for as long as the controller acknowledges. The block pulls the data line low only through an open-drain enable. The bus itself is the wired-AND of all drivers, with a pull-up.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: An address byte whose bits 7:4 equal 1010 and whose bits 3:1 equal `strap_i` is acknowledged. Bit 0 of that byte selects the direction: 0 means the controller writes and 1 means the controller reads.
- R2: An address byte that differs in the prefix or in the strap bits gets no acknowledge. The device then drives nothing and stores nothing until the next start condition.
- R3: The device acknowledges a received byte by holding the data line low for the whole ninth clock pulse. It releases the line on the following clock fall. The enable `sda_oe` changes only while the sampled clock is low.
- R4: A data fall while the clock is high is a start, and a data rise while the clock is high is a stop. Either one abandons a partly received byte. A start restarts the bit and byte count, so a full transaction that follows a partial byte works normally.
- R5: In a write transaction, the first byte after the address loads the pointer and stores nothing. Each later byte is stored at the pointer. A transaction that stops right after the pointer byte leaves the memory unchanged.
- R6: After a read address, the device shifts out the byte at the pointer, most significant bit first, on the 8 clock pulses that follow its acknowledge. The result is a random read when a repeated start follows a pointer-only write.
- R7: The pointer advances by one after each byte stored and after each byte sent, and it wraps from 255 to 0. The memory holds 256 bytes.
- R8: If the controller answers a read byte with a not-acknowledge (data high on the ninth pulse), the device releases the data line and stays released until the next start or stop.
- R9: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Board strap bits compared with address bits 3:1 |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Storing a byte at pointer 255 and wrapping the pointer to 0 happen in the same system clock cycle, on the clock fall that ends the eighth data bit. The bench provokes this case with one write transaction. It sets the pointer to 255 and sends two data bytes. It then reads locations 255 and 0 back in one sequential read. The check passes only if both bytes land where expected and the second byte does not overwrite the first.

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave #(
  parameter int          AW         = 8,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} ph_t;

  logic [2:0]    scl_q, sda_q;
  st_t           state;
  ph_t           phase;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          byte_full, rd_mode, mst_ack;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  wire [7:0] rx_byte = shreg;
  wire       addr_hit = (rx_byte[7:4] == DEV_PREFIX) && (rx_byte[3:1] == strap_i);
  wire       wr_en = (state == ST_RX) && scl_fall && byte_full && (phase == PH_DATA)
                     && !start_det && !stop_det;
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= 3'd0;
      shreg     <= 8'd0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
      mst_ack   <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_RX;
      phase     <= PH_ADDR;
      bit_cnt   <= 3'd0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      bit_cnt   <= 3'd0;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && !byte_full) begin
            shreg   <= {shreg[6:0], sda_q[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            bit_cnt   <= 3'd0;
            case (phase)
              PH_ADDR: begin
                if (addr_hit) begin
                  rd_mode <= rx_byte[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr    <= rx_byte[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
              default: begin
                ptr    <= ptr + 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= 3'd0;
            if (rd_mode) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              phase  <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_TX_ACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_q[1];
          end else if (scl_fall) begin
            bit_cnt <= 3'd0;
            if (mst_ack) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          start_det,
  input logic [2:0]    st,
  input logic [2:0]    bit_cnt,
  input logic          wr_en,
  input logic [AW-1:0] ptr
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_RX   = 3'd1;

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);                                     // R3
  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX) |-> !sda_oe);                                        // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);                                      // R2
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_RX) && (bit_cnt == 3'd0));                 // R4
  AST_PTR_STEP_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == AW'($past(ptr) + 1'b1));                         // R7
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_q[1]),
  .start_det(start_det), .st(state), .bit_cnt(bit_cnt),
  .wr_en(wr_en), .ptr(ptr)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AD_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] AD_R = {4'b1010, STRAP, 1'b1};
  localparam int NV = 10;
  // {is_read, pointer, data}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h5A}, {1'b0, 8'h01, 8'hC3}, {1'b0, 8'h7F, 8'h81},
    {1'b0, 8'h80, 8'h3C}, {1'b1, 8'h01, 8'hC3}, {1'b1, 8'h00, 8'h5A},
    {1'b1, 8'h80, 8'h3C}, {1'b1, 8'h7F, 8'h81}, {1'b0, 8'h01, 8'h96},
    {1'b1, 8'h01, 8'h96}};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  wire  sda_bus = ~(m_low | sda_oe);
  int   n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                          .strap_i(STRAP), .sda_oe(sda_oe));

  task automatic qd(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bstart();
    m_low = 1'b0; qd(); scl = 1'b1; qd(); m_low = 1'b1; qd(); scl = 1'b0; qd();
  endtask

  task automatic bstop();
    m_low = 1'b1; qd(); scl = 1'b1; qd(); m_low = 1'b0; qd();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd();
    end
  endtask

  // ack=0 only if the line is low at both ends of the ninth pulse
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    send_bits(b, 8);
    m_low = 1'b0; qd(); scl = 1'b1; @(negedge clk); @(negedge clk); @(negedge clk);
    @(negedge clk); a1 = sda_bus; qd(); a2 = sda_bus; scl = 1'b0; qd();
    ack = a1 | a2;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qd(); scl = 1'b1; qd(); b[i] = sda_bus; qd(); scl = 1'b0;
    end
    m_low = give_ack; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd(); m_low = 1'b0;
  endtask

  task automatic wr(input string req, input logic [7:0] p, input logic [7:0] d);
    logic a;
    bstart();
    send_byte(AD_W, a); chk({req, " addr ack"}, {7'd0, a}, 8'd0);
    send_byte(p, a);    chk({req, " ptr ack"}, {7'd0, a}, 8'd0);
    send_byte(d, a);    chk({req, " data ack"}, {7'd0, a}, 8'd0);
    chk({req, " released after ack"}, {7'd0, sda_oe}, 8'd0);
    bstop();
  endtask

  task automatic rd(input string req, input logic [7:0] p, input logic [7:0] exp);
    logic a; logic [7:0] d;
    bstart();
    send_byte(AD_W, a); chk({req, " addr ack"}, {7'd0, a}, 8'd0);
    send_byte(p, a);    chk({req, " ptr ack"}, {7'd0, a}, 8'd0);
    bstart();
    send_byte(AD_R, a); chk({req, " read addr ack"}, {7'd0, a}, 8'd0);
    recv_byte(d, 1'b0); chk({req, " read data"}, d, exp);
    bstop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a; logic [7:0] d0, d1;
    repeat (4) @(negedge clk);
    chk("R9 reset release", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    qd();
    chk("R9 idle release", {7'd0, sda_oe}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) rd("R6 R1 vec read", VEC[v][15:8], VEC[v][7:0]);
      else            wr("R5 R1 vec write", VEC[v][15:8], VEC[v][7:0]);
    end

    // R2: wrong strap, then wrong prefix; later bytes must be ignored
    wr("R2 setup", 8'h10, 8'h11);
    bstart();
    send_byte({4'b1010, 3'b010, 1'b0}, a); chk("R2 strap nack", {7'd0, a}, 8'd1);
    send_byte(8'h10, a); chk("R2 ignored ptr", {7'd0, a}, 8'd1);
    send_byte(8'hEE, a); chk("R2 ignored data", {7'd0, a}, 8'd1);
    bstop();
    bstart();
    send_byte({4'b1011, STRAP, 1'b0}, a); chk("R2 prefix nack", {7'd0, a}, 8'd1);
    send_byte(8'h10, a); send_byte(8'hDD, a);
    bstop();
    rd("R2 memory untouched", 8'h10, 8'h11);

    // R5: pointer-only write stores nothing
    wr("R5 setup", 8'h30, 8'h5C);
    bstart();
    send_byte(AD_W, a); send_byte(8'h30, a); chk("R5 ptr-only ack", {7'd0, a}, 8'd0);
    bstop();
    rd("R5 ptr-only leaves data", 8'h30, 8'h5C);

    // R4: partial byte then repeated start; partial byte then stop
    bstart();
    send_bits(8'hF0, 4);
    wr("R4 after partial byte", 8'h20, 8'h77);
    rd("R4 restart write", 8'h20, 8'h77);
    wr("R4 setup", 8'h21, 8'h44);
    bstart();
    send_byte(AD_W, a); send_byte(8'h21, a);
    send_bits(8'h00, 3);
    bstop();
    rd("R4 stop aborts byte", 8'h21, 8'h44);

    // R7: store at 255 and wrap in one transaction, then sequential read
    bstart();
    send_byte(AD_W, a); send_byte(8'hFF, a);
    send_byte(8'hA1, a); chk("R7 store 255 ack", {7'd0, a}, 8'd0);
    send_byte(8'hB2, a); chk("R7 store 0 ack", {7'd0, a}, 8'd0);
    bstop();
    bstart();
    send_byte(AD_W, a); send_byte(8'hFF, a);
    bstart();
    send_byte(AD_R, a);
    recv_byte(d0, 1'b1); chk("R7 R6 read 255", d0, 8'hA1);
    recv_byte(d1, 1'b0); chk("R7 read wrapped 0", d1, 8'hB2);
    // R8: after NACK the line stays released through a full SCL pulse
    chk("R8 released after nack", {7'd0, sda_oe}, 8'd0);
    m_low = 1'b0; qd(); scl = 1'b1; qd(); chk("R8 no drive", {7'd0, sda_bus}, 8'd1);
    qd(); scl = 1'b0; qd();
    bstop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule